// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Frame Length

This block receives asynchronous serial frames on a single input line. It divides the system clock down to a tick at sixteen times the bit rate and watches the line for a falling edge. It accepts a start bit only if the line is still low half a bit later. From then on it samples each bit once, at the middle of the bit. A frame carries 5 to 8 data bits, least significant bit first, followed by an optional parity bit and then a stop bit.

When the first stop bit is sampled, the received bits move into a one-entry holding buffer and a receive-complete flag goes high. Parity and framing status are stored with the data. The receiver never waits for a second stop bit. Software or a host engine reads `rxData` and pulses `rdStrobe` to release the buffer. Bits above the selected frame width always read as zero.

The format inputs are captured when a start bit is accepted. A later change to them does not disturb a frame that is already being received. When `rxEn` is low the receiver ignores the line and abandons any partial frame.

Top module: `uart_rx_varlen`

## Requirements
- R1: A low level on `rxLine` starts a frame only if the line is still low at the eighth tick after the falling edge was seen (mid start bit). A shorter low pulse produces no frame, and the receiver stays ready for the next falling edge.
- R2: `frameBits` selects the data width: code 0 is 5 bits, 1 is 6, 2 is 7 and 3 is 8. Data bits arrive least significant first, and each bit is sampled at its centre.
- R3: When the frame is narrower than 8 bits, the bits of `rxData` above the frame width are zero.
- R4: When `parityEn` is high, one parity bit follows the last data bit. `parityOdd` = 0 selects even parity, meaning data plus parity hold an even number of ones; `parityOdd` = 1 selects odd parity. A mismatch sets `parityErr`, which is stored with that frame's data. With parity off, `parityErr` is 0.
- R5: If the first stop bit is sampled low, `frameErr` is set and stored with that frame's data. Otherwise it is 0.
- R6: `rxDone` rises at the centre of the first stop bit. No second stop bit is waited for or checked, so a start bit that directly follows one stop bit is received correctly.
- R7: A one-cycle `rdStrobe` clears `rxDone` and `overrun`. A frame that completes while `rxDone` is still set overwrites the buffer and sets `overrun`.
- R8: While `rxEn` is low, line activity produces no frame. Dropping `rxEn` in the middle of a frame discards that frame.
- R9: After reset, `rxData`, `rxDone`, `parityErr`, `frameErr` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receiver enable |
| rxLine | input | 1 | Serial input line, idle high |
| frameBits | input | 2 | Data width code (5 + code bits) |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| rdStrobe | input | 1 | Buffer read strobe; clears flags |
| rxData | output | 8 | Buffered data, upper bits zero-filled |
| rxDone | output | 1 | Receive-complete flag |
| parityErr | output | 1 | Parity mismatch on buffered frame |
| frameErr | output | 1 | Stop bit low on buffered frame |
| overrun | output | 1 | Buffer overwritten before it was read |

## Verification
The bench builds the receiver with `TICK_DIV` = 4, so one bit lasts 64 clocks. The bench can therefore check `rxDone` partway through the stop bit, after its centre but well before its end. This short bit period also leaves room for dozens of random frames covering every width, both parity senses and injected parity and stop-bit errors. Directed cases cover a short start glitch, back-to-back frames with a single stop bit, an overrun, a disabled receiver and a frame aborted by dropping the enable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_DATA   = 3'd2,
    S_PARITY = 3'd3,
    S_STOP   = 3'd4
  } rxState_t;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic clearShift;
    logic shiftBit;
    logic captParity;
    logic loadBuf;
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxEn,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = rxEn;
    end else begin : g_div
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          divCnt <= '0;
        end else if (!rxEn) begin
          divCnt <= '0;
        end else if (divCnt == CW'(TICK_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign tick = rxEn && (divCnt == CW'(TICK_DIV - 1));
    end
  endgenerate

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MIN_BITS   = 5,
  parameter int DATA_MAX   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEn,
  input  logic       tick,
  input  logic       rxSync,
  input  logic [1:0] frameBits,
  input  logic       parityEn,
  input  logic       parityOdd,
  output rxStrobe_t  strobe,
  output logic [1:0] fmtBits,
  output logic       fmtParEn,
  output logic       fmtParOdd
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = IDX_W'(fmtBits) + IDX_W'(MIN_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      fmtBits   <= '0;
      fmtParEn  <= 1'b0;
      fmtParOdd <= 1'b0;
    end else if (!rxEn) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      unique case (state)
        S_IDLE: begin
          if (!rxSync) begin
            state     <= S_START;
            tickCnt   <= '0;
            fmtBits   <= frameBits;
            fmtParEn  <= parityEn;
            fmtParOdd <= parityOdd;
          end
        end
        S_START: begin
          if (tickCnt == MID) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? S_IDLE : S_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) begin
              state <= fmtParEn ? S_PARITY : S_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PARITY: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            state   <= S_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (tickCnt == LAST) begin
            tickCnt <= '0;
            state   <= S_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic atLast;
  assign atLast = rxEn && tick && (tickCnt == LAST);

  always_comb begin
    strobe            = '0;
    strobe.clearShift = rxEn && tick && (state == S_START) && (tickCnt == MID) && !rxSync;
    strobe.shiftBit   = atLast && (state == S_DATA);
    strobe.captParity = atLast && (state == S_PARITY);
    strobe.loadBuf    = atLast && (state == S_STOP);
  end

  // R8: a disabled receiver is parked idle on the next cycle
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEn |=> (state == S_IDLE));

  // R2: bit index never passes the latched frame width
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (bitIdx <= lastIdx));

  // R1: a start bit seen high at its centre returns to idle
  a_r1_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEn && tick && state == S_START && tickCnt == MID && rxSync) |=> (state == S_IDLE));

  // R6: at most one strobe per cycle
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int MIN_BITS    = 5,
  parameter int DATA_MAX    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxLine,
  input  rxStrobe_t           strobe,
  input  logic [1:0]          fmtBits,
  input  logic                fmtParEn,
  input  logic                fmtParOdd,
  input  logic                rdStrobe,
  output logic                rxSync,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxDone,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrun
);
  localparam int SH_W = $clog2(DATA_MAX) + 1;

  logic [SYNC_STAGES-1:0] syncReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncReg <= '1;
    else        syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
  end
  assign rxSync = syncReg[SYNC_STAGES-1];

  logic [DATA_MAX-1:0] shiftReg;
  logic                parBit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {rxSync, shiftReg[DATA_MAX-1:1]};
    end else if (strobe.captParity) begin
      parBit <= rxSync;
    end
  end

  // Right-justify: first bit received sits at DATA_MAX - width.
  logic [SH_W-1:0]     shAmt;
  logic [DATA_MAX-1:0] aligned;
  logic                parMismatch;
  assign shAmt       = SH_W'(DATA_MAX - MIN_BITS) - SH_W'(fmtBits);
  assign aligned     = shiftReg >> shAmt;
  assign parMismatch = fmtParEn && ((^aligned ^ parBit) != fmtParOdd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData    <= '0;
      rxDone    <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
    end else if (strobe.loadBuf) begin
      rxData    <= aligned;
      rxDone    <= 1'b1;
      parityErr <= parMismatch;
      frameErr  <= !rxSync;
      overrun   <= (rxDone || overrun) && !rdStrobe;
    end else if (rdStrobe) begin
      rxDone  <= 1'b0;
      overrun <= 1'b0;
    end
  end

  // R6: the buffer load raises the completion flag
  a_r6_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadBuf |=> rxDone);

  // R7: a read with no concurrent load clears both flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !strobe.loadBuf) |=> (!rxDone && !overrun));

  // R7: an unread buffer that is overwritten flags overrun
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadBuf && rxDone && !rdStrobe) |=> overrun);

  // R3: bits above the frame width are zero after a load
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadBuf |=> ((rxData >> (MIN_BITS + int'($past(fmtBits)))) == '0));

endmodule

// File: rtl/uart_rx_varlen.sv
module uart_rx_varlen
  import uart_rx_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEn,
  input  logic       rxLine,
  input  logic [1:0] frameBits,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       rdStrobe,
  output logic [7:0] rxData,
  output logic       rxDone,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrun
);
  localparam int MIN_BITS = 5;
  localparam int DATA_MAX = 8;

  logic      tick;
  logic      rxSync;
  rxStrobe_t strobe;
  logic [1:0] fmtBits;
  logic      fmtParEn;
  logic      fmtParOdd;

  uart_rx_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .tick(tick)
  );

  uart_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE), .MIN_BITS(MIN_BITS), .DATA_MAX(DATA_MAX)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .tick(tick), .rxSync(rxSync),
    .frameBits(frameBits), .parityEn(parityEn), .parityOdd(parityOdd),
    .strobe(strobe), .fmtBits(fmtBits), .fmtParEn(fmtParEn), .fmtParOdd(fmtParOdd)
  );

  uart_rx_dpath #(
    .MIN_BITS(MIN_BITS), .DATA_MAX(DATA_MAX), .SYNC_STAGES(SYNC_STAGES)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .strobe(strobe),
    .fmtBits(fmtBits), .fmtParEn(fmtParEn), .fmtParOdd(fmtParOdd),
    .rdStrobe(rdStrobe), .rxSync(rxSync), .rxData(rxData), .rxDone(rxDone),
    .parityErr(parityErr), .frameErr(frameErr), .overrun(overrun)
  );

endmodule

// File: tb/uart_rx_varlen_tb_top.sv
`timescale 1ns/1ps
module uart_rx_varlen_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT      = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxEn = 1'b0;
  logic rxLine = 1'b1;
  logic [1:0] frameBits = 2'd3;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic rxDone, parityErr, frameErr, overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_varlen #(.TICK_DIV(TICK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .rxLine(rxLine),
    .frameBits(frameBits), .parityEn(parityEn), .parityOdd(parityOdd),
    .rdStrobe(rdStrobe), .rxData(rxData), .rxDone(rxDone),
    .parityErr(parityErr), .frameErr(frameErr), .overrun(overrun)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  function automatic logic parityFor(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  // Drive start, data, parity and the first 3/4 of the stop bit.
  task automatic sendFrame(input logic [7:0] d, input int nb, input bit pe, input bit po,
                           input bit badPar, input bit badStop);
    rxLine = 1'b0; waitClk(BIT);
    for (int i = 0; i < nb; i++) begin
      rxLine = d[i]; waitClk(BIT);
    end
    if (pe) begin
      rxLine = parityFor(maskData(d, nb), po) ^ badPar; waitClk(BIT);
    end
    rxLine = !badStop; waitClk(BIT * 3 / 4);
  endtask

  task automatic finishStop();
    rxLine = 1'b1; waitClk(BIT / 4);
  endtask

  task automatic readBuf();
    rdStrobe = 1'b1; waitClk(1); rdStrobe = 1'b0;
  endtask

  task automatic setFmt(input int nb, input bit pe, input bit po);
    frameBits = 2'(nb - 5); parityEn = pe; parityOdd = po;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R9: reset state
    check({rxData, rxDone, parityErr, frameErr, overrun} == 12'h0, "R9 reset outputs",
          {rxData, rxDone, parityErr, frameErr, overrun}, 0);
    rst_n = 1'b1; waitClk(2);
    rxEn = 1'b1; waitClk(BIT);

    // R1: short glitch is rejected, then a real frame is taken
    setFmt(8, 0, 0);
    rxLine = 1'b0; waitClk(2 * TICK_DIV); rxLine = 1'b1; waitClk(2 * BIT);
    check(rxDone == 1'b0, "R1 glitch gives no frame", rxDone, 0);
    sendFrame(8'hA5, 8, 0, 0, 0, 0);
    check(rxDone == 1'b1, "R6 done within first stop bit", rxDone, 1);
    finishStop();
    check(rxData == 8'hA5, "R1 frame after glitch", rxData, 8'hA5);
    readBuf();
    check(rxDone == 1'b0, "R7 read clears done", rxDone, 0);

    // R3: 5-bit frame with ones on the line beyond the width
    setFmt(5, 0, 0);
    sendFrame(8'hFF, 5, 0, 0, 0, 0); finishStop();
    rxLine = 1'b1; waitClk(BIT);
    check(rxData == 8'h1F, "R3 upper bits zero", rxData, 8'h1F);
    readBuf();

    // R6: back-to-back frames with one stop bit; R7 overrun
    setFmt(8, 1, 0);
    sendFrame(8'h3C, 8, 1, 0, 0, 0); finishStop();
    sendFrame(8'hC7, 8, 1, 0, 0, 0); finishStop();
    check(rxData == 8'hC7, "R6 back-to-back second frame", rxData, 8'hC7);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    check(parityErr == 1'b0, "R4 even parity good", parityErr, 0);
    readBuf();
    check({rxDone, overrun} == 2'b00, "R7 read clears overrun", {rxDone, overrun}, 0);

    // R8: disabled receiver ignores a whole frame
    rxEn = 1'b0;
    sendFrame(8'h11, 8, 1, 0, 0, 0); finishStop();
    check(rxDone == 1'b0, "R8 disabled ignores line", rxDone, 0);
    rxEn = 1'b1; waitClk(BIT);

    // R8: abort mid-frame
    rxLine = 1'b0; waitClk(BIT * 3);
    rxEn = 1'b0; waitClk(4); rxEn = 1'b1;
    rxLine = 1'b1; waitClk(BIT * 12);
    check(rxDone == 1'b0, "R8 aborted frame discarded", rxDone, 0);
    setFmt(7, 1, 1);
    sendFrame(8'h55, 7, 1, 1, 0, 0); finishStop();
    check(rxData == 8'h55 && !parityErr, "R8 receive after abort", {parityErr, rxData}, 8'h55);
    readBuf();

    // R2 R4 R5: random frames
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 48; k++) begin
      int nb = 5 + int'($urandom % 4);
      bit pe = 1'($urandom % 2);
      bit po = 1'($urandom % 2);
      bit bp = ($urandom % 6) == 0;
      bit bs = ($urandom % 7) == 0;
      logic [7:0] d = 8'($urandom);
      setFmt(nb, pe, po);
      sendFrame(d, nb, pe, po, bp, bs);
      check(rxDone == 1'b1, "R6 done mid stop", rxDone, 1);
      finishStop();
      frameBits = 2'($urandom);
      check(rxData == maskData(d, nb), "R2 data", rxData, maskData(d, nb));
      if (nb < 8) check((rxData >> nb) == 0, "R3 zero fill", rxData, maskData(d, nb));
      check(parityErr == (pe && bp), "R4 parity error", parityErr, pe && bp);
      check(frameErr == bs, "R5 frame error", frameErr, bs);
      check(overrun == 1'b0, "R7 no overrun", overrun, 0);
      readBuf();
      check(rxDone == 1'b0, "R7 cleared", rxDone, 0);
      waitClk(BIT / 2 + int'($urandom % 40));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule